// File: doc/BRIEF.md
# Bitwise Logic Unit with Status Flags

This block carries out the bitwise group of a processor datapath: AND, OR, XOR, NOT and TEST on byte or word operands, plus the two carry-only operations that force carry high or invert it. A width select picks byte or word operation. One operation is accepted per clock on a valid strobe. The block returns a registered result, a registered write-enable for the destination register, and a registered six-bit status word.

Each opcode follows its own flag policy. The three two-operand logic operations and TEST clear carry and overflow and derive parity, zero and sign from the result. NOT touches no flag. TEST produces the flags but does not write back. The carry operations touch carry alone. Auxiliary carry is never altered by this unit. Unassigned opcodes pass the destination through without a write and leave the flags alone. A synchronous reset clears every register.

Top module: `logic_flag_unit`

## Requirements
- R1: Opcode encoding on `in_op`: 0 AND, 1 OR, 2 XOR, 3 NOT, 4 TEST, 5 set-carry, 6 complement-carry, 7 unassigned. For AND, OR and XOR, the bitwise result of `in_dst` and `in_src` appears on `out_result`, with `out_wr_en` high, one cycle after the edge where `in_valid` is high.
- R2: Status bits are carry=0, parity=1, aux=2, zero=3, sign=4, overflow=5. AND, OR, XOR and TEST force carry (bit 0) and overflow (bit 5) to 0.
- R3: For AND, OR, XOR and TEST, parity (bit 1) is 1 when the low 8 bits of the result hold an even number of ones, and 0 otherwise, in both widths.
- R4: For AND, OR, XOR and TEST, zero (bit 3) is 1 exactly when the result is zero at the selected width. In byte mode the upper operand bits do not count.
- R5: For AND, OR, XOR and TEST, sign (bit 4) equals result bit 7 in byte mode and result bit 15 in word mode.
- R6: NOT (opcode 3) outputs the inverted destination with `out_wr_en` high and leaves all six status bits unchanged.
- R7: TEST (opcode 4) sets the flags as AND would and shows the AND value on `out_result`, with `out_wr_en` low.
- R8: Set-carry (opcode 5) makes carry 1 and leaves bits 5..1 unchanged, with `out_wr_en` low.
- R9: Complement-carry (opcode 6) inverts carry and leaves bits 5..1 unchanged, with `out_wr_en` low.
- R10: No operation changes aux (bit 2). It holds its value from the previous cycle.
- R11: In byte mode (`in_word`=0), bits 15..8 of `out_result` are 0 for every opcode.
- R12: In a cycle with `in_valid` low, `out_wr_en` goes low on the next edge and `out_result` and `out_flags` hold.
- R13: A synchronous active-high `rst` clears `out_result`, `out_wr_en` and `out_flags` to 0 on the next edge.
- R14: The unassigned opcode 7 outputs the destination at the selected width, with `out_wr_en` low and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode |
| in_word | input | 1 | 1 selects word width, 0 selects byte width |
| in_dst | input | 16 | Destination operand |
| in_src | input | 16 | Source operand |
| out_result | output | 16 | Registered result |
| out_wr_en | output | 1 | Registered destination write-enable |
| out_flags | output | 6 | Registered status word |

## Verification
A wrong flag policy shows up in `out_flags` one cycle after the operation. A policy error that touches the sticky bits, such as carry surviving a logic operation or NOT disturbing the flags, persists. It then also corrupts the expected value of every later vector until a clearing operation runs. A width or mask fault shows in `out_result` on the same edge, through nonzero upper bits or a wrong zero flag on byte operations with a dirty upper byte. Write-enable errors for TEST and the carry operations appear as a high `out_wr_en` in the cycle after they are issued.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_NOT  = 3'd3,
    OP_TEST = 3'd4,
    OP_SETC = 3'd5,
    OP_CMPC = 3'd6,
    OP_NONE = 3'd7
  } op_t;

  localparam int FLAG_W  = 6;
  localparam int FL_CARRY = 0;
  localparam int FL_PAR   = 1;
  localparam int FL_AUX   = 2;
  localparam int FL_ZERO  = 3;
  localparam int FL_SIGN  = 4;
  localparam int FL_OVF   = 5;

  function automatic logic is_logic2(op_t op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
  endfunction
endpackage

// File: rtl/lfu_bitwise.sv
module lfu_bitwise
  import lfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  op_t               op,
  input  logic              word,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] res,
  output logic              wr
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] mask;

  // Lane 0 is always live; upper lanes only in word mode.
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
        assign mask[LANE_W-1:0] = '1;
      end else begin : g_high
        assign mask[g*LANE_W +: LANE_W] = {LANE_W{word}};
      end
    end
  endgenerate

  always_comb begin
    raw = dst;
    wr  = 1'b0;
    unique case (op)
      OP_AND:  begin raw = dst & src; wr = 1'b1; end
      OP_OR:   begin raw = dst | src; wr = 1'b1; end
      OP_XOR:  begin raw = dst ^ src; wr = 1'b1; end
      OP_NOT:  begin raw = ~dst;      wr = 1'b1; end
      OP_TEST: begin raw = dst & src; wr = 1'b0; end
      default: begin raw = dst;       wr = 1'b0; end
    endcase
  end

  assign res = raw & mask;
endmodule

// File: rtl/lfu_flag_eval.sv
module lfu_flag_eval #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              word,
  output logic              par,
  output logic              zero,
  output logic              sign
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_nz;
  logic             upper_nz;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_nz
      assign lane_nz[g] = |res[g*LANE_W +: LANE_W];
    end
    if (LANES > 1) begin : g_up
      assign upper_nz = |lane_nz[LANES-1:1];
    end else begin : g_noup
      assign upper_nz = 1'b0;
    end
  endgenerate

  assign par  = ~^res[LANE_W-1:0];
  assign zero = ~(lane_nz[0] | (word & upper_nz));
  assign sign = word ? res[DATA_W-1] : res[LANE_W-1];
endmodule

// File: rtl/lfu_flag_reg.sv
module lfu_flag_reg
  import lfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  op_t               op,
  input  logic              par,
  input  logic              zero,
  input  logic              sign,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    flags_d = flags;
    if (valid) begin
      if (is_logic2(op)) begin
        flags_d[FL_CARRY] = 1'b0;
        flags_d[FL_OVF]   = 1'b0;
        flags_d[FL_PAR]   = par;
        flags_d[FL_ZERO]  = zero;
        flags_d[FL_SIGN]  = sign;
      end else if (op == OP_SETC) begin
        flags_d[FL_CARRY] = 1'b1;
      end else if (op == OP_CMPC) begin
        flags_d[FL_CARRY] = ~flags[FL_CARRY];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_d;
  end
endmodule

// File: rtl/logic_flag_unit.sv
module logic_flag_unit
  import lfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic              in_word,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic [FLAG_W-1:0] out_flags
);
  op_t               op;
  logic [DATA_W-1:0] res;
  logic              wr;
  logic              par, zero, sign;

  assign op = op_t'(in_op);

  lfu_bitwise #(.DATA_W(DATA_W), .LANE_W(LANE_W)) bw_i (
    .op(op), .word(in_word), .dst(in_dst), .src(in_src), .res(res), .wr(wr)
  );

  lfu_flag_eval #(.DATA_W(DATA_W), .LANE_W(LANE_W)) fe_i (
    .res(res), .word(in_word), .par(par), .zero(zero), .sign(sign)
  );

  lfu_flag_reg fr_i (
    .clk(clk), .rst(rst), .valid(in_valid), .op(op),
    .par(par), .zero(zero), .sign(sign), .flags(out_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_result <= '0;
      out_wr_en  <= 1'b0;
    end else if (in_valid) begin
      out_result <= res;
      out_wr_en  <= wr;
    end else begin
      out_wr_en  <= 1'b0;
    end
  end
endmodule

// File: rtl/lfu_checker.sv
module lfu_checker #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic              in_word,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr_en,
  input logic [5:0]        out_flags
);
  assert_logic_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 3'd0 || in_op == 3'd1 || in_op == 3'd2 || in_op == 3'd4))
      |=> (out_flags[0] == 1'b0 && out_flags[5] == 1'b0));

  assert_not_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd3) |=> ($stable(out_flags) && out_wr_en));

  assert_test_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd4) |=> !out_wr_en);

  assert_setc_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd5) |=> (out_flags[0] && $stable(out_flags[5:1]) && !out_wr_en));

  assert_cmpc_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd6) |=> (out_flags[0] != $past(out_flags[0]) && $stable(out_flags[5:1])));

  assert_aux_hold_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(out_flags[2]));

  assert_byte_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_word) |=> (out_result[DATA_W-1:LANE_W] == '0));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_wr_en && $stable(out_flags) && $stable(out_result)));

  assert_none_op_R14: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd7) |=> (!out_wr_en && $stable(out_flags)));
endmodule

bind logic_flag_unit lfu_checker #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_word(in_word),
  .out_result(out_result), .out_wr_en(out_wr_en), .out_flags(out_flags)
);

// File: tb/logic_flag_unit_tb.sv
module logic_flag_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic        in_word = 1'b0;
  logic [15:0] in_dst = '0;
  logic [15:0] in_src = '0;
  logic [15:0] out_result;
  logic        out_wr_en;
  logic [5:0]  out_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_flag_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_word(in_word),
    .in_dst(in_dst), .in_src(in_src), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  // {op, word, dst, src, exp_result, exp_we, exp_flags}; flags {O,S,Z,A,P,C}
  localparam logic [58:0] VECS [NVEC] = '{
    {3'd0, 1'b1, 16'hF0F0, 16'hFF00, 16'hF000, 1'b1, 6'h12}, // R1 R3 R5 AND word
    {3'd5, 1'b1, 16'h1234, 16'h0000, 16'h1234, 1'b0, 6'h13}, // R8 set carry
    {3'd1, 1'b0, 16'hAB0C, 16'h0030, 16'h003C, 1'b1, 6'h02}, // R2 R11 OR byte
    {3'd6, 1'b1, 16'h5555, 16'h0000, 16'h5555, 1'b0, 6'h03}, // R9 complement
    {3'd3, 1'b0, 16'h12F0, 16'h0000, 16'h000F, 1'b1, 6'h03}, // R6 NOT byte
    {3'd2, 1'b1, 16'hA5A5, 16'hA5A5, 16'h0000, 1'b1, 6'h0A}, // R4 XOR zero
    {3'd4, 1'b0, 16'h0005, 16'h0002, 16'h0000, 1'b0, 6'h0A}, // R7 TEST zero
    {3'd4, 1'b0, 16'h0005, 16'h0001, 16'h0001, 1'b0, 6'h00}, // R7 R3 odd
    {3'd6, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 6'h01}, // R9 0->1
    {3'd3, 1'b1, 16'h00FF, 16'h0000, 16'hFF00, 1'b1, 6'h01}, // R6 NOT word
    {3'd2, 1'b0, 16'h00FC, 16'h0003, 16'h00FF, 1'b1, 6'h12}, // R2 R5 clears C
    {3'd7, 1'b1, 16'hBEEF, 16'h1111, 16'hBEEF, 1'b0, 6'h12}, // R14 none
    {3'd0, 1'b0, 16'hFF80, 16'hFF80, 16'h0080, 1'b1, 6'h10}, // R5 R11 byte sign
    {3'd5, 1'b0, 16'hABCD, 16'h0000, 16'h00CD, 1'b0, 6'h11}, // R8 R11
    {3'd1, 1'b1, 16'h8000, 16'h0001, 16'h8001, 1'b1, 6'h10}, // R5 word sign
    {3'd0, 1'b1, 16'h0100, 16'h0100, 16'h0100, 1'b1, 6'h02}, // R3 R4 word
    {3'd2, 1'b0, 16'h0100, 16'h0000, 16'h0000, 1'b1, 6'h0A}  // R4 byte zero
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic w, logic [15:0] d, logic [15:0] s);
    in_valid = 1'b1; in_op = op; in_word = w; in_dst = d; in_src = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [15:0] hold_res;
    logic [5:0]  hold_flags;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 result", out_result, 16'h0);
    check("R13 wr_en", {15'h0, out_wr_en}, 16'h0);
    check("R13 flags", {10'h0, out_flags}, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [58:0] v;
      v = VECS[i];
      issue(v[58:56], v[55], v[54:39], v[38:23]);
      check($sformatf("R1 vec%0d result", i), out_result, v[22:7]);
      check($sformatf("R7 vec%0d wr_en", i), {15'h0, out_wr_en}, {15'h0, v[6]});
      check($sformatf("R2 vec%0d flags", i), {10'h0, out_flags}, {10'h0, v[5:0]});
      check($sformatf("R10 vec%0d aux", i), {15'h0, out_flags[2]}, 16'h0);
    end

    // R12 idle: hold result and flags, drop write enable
    issue(3'd0, 1'b1, 16'h0F0F, 16'h0F0F);
    hold_res = out_result;
    hold_flags = out_flags;
    in_op = 3'd6; in_dst = 16'hFFFF;
    repeat (2) @(negedge clk);
    check("R12 wr_en", {15'h0, out_wr_en}, 16'h0);
    check("R12 result", out_result, hold_res);
    check("R12 flags", {10'h0, out_flags}, {10'h0, hold_flags});

    // R13 reset after carry set
    issue(3'd5, 1'b1, 16'h7777, 16'h0);
    check("R8 carry set", {15'h0, out_flags[0]}, 16'h1);
    issue(3'd0, 1'b1, 16'hFFFF, 16'hFFFF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R13 flags cleared", {10'h0, out_flags}, 16'h0);
    check("R13 result cleared", out_result, 16'h0);
    check("R13 wr_en cleared", {15'h0, out_wr_en}, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule